// File: doc/BRIEF.md
# Framebuffer Scan-Out Controller

This block scans a true-colour image out of word-addressed memory onto a TFT or VGA style pixel interface. A free-running raster generator produces horizontal and vertical sync (both active low) and a data-enable strobe. For every visible pixel position it issues one word read on a request/valid memory port. It splits each returned 32-bit word into 8-bit red, green and blue, and drives the colour with the same two-cycle delay as the sync and enable outputs.

Software sees two word-indexed registers. Index 0 holds the frame base byte address; only its upper bits take part in addressing. Index 1 holds a display enable bit and a 180-degree rotation bit. Each image row sits at a fixed word stride in memory, and only the visible words of a row are ever read. Register changes act only at the start of vertical blanking, so a frame never shows two configurations. The raster defaults to the standard 640x480 timing, and every timing figure is a parameter. The memory answers one cycle after each request, with `mem_valid` high and the word on `mem_rdata`.

Top module: `scanout_ctrl`

## Requirements
- R1: While reset is held and just after it, `de` is 0, the colour outputs are 0, `hsync_n` and `vsync_n` are 1, `mem_req` is 0, and both registers read 0.
- R2: A line lasts H_ACTIVE+H_FRONT+H_SYNC+H_BACK clocks. `de` is high for exactly H_ACTIVE consecutive clocks of each visible line. `hsync_n` goes low H_FRONT clocks after `de` falls and stays low for H_SYNC clocks.
- R3: A frame lasts V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines, and exactly V_ACTIVE lines carry `de`. `vsync_n` falls at the start of the line V_FRONT lines after the last visible line, and stays low for V_SYNC whole lines.
- R4: Register index 0 reads back all ADDR_W bits exactly as written. Register index 1 keeps bit 0 (enable) and bit 1 (rotate), and its other bits read 0.
- R5: Only the top BASE_KEEP bits of the base register take part in addressing. The lower bits are treated as zero.
- R6: Without rotation, the pixel in column x of visible line y is read from byte address base + (y*ROW_STRIDE + x)*4. Only H_ACTIVE words per row are requested.
- R7: With rotation, the pixel in column x of visible line y is read from row V_ACTIVE-1-y, word H_ACTIVE-1-x. The first pixel of a frame therefore comes from the last visible word of the last row.
- R8: Red is word bits 23:16, green is bits 15:8 and blue is bits 7:0. Bits 31:24 have no effect.
- R9: While the frame's enable bit is 0, no memory request is issued and the colour outputs stay 0, while sync and `de` timing continue unchanged.
- R10: A register write takes effect only from the first frame that begins after the next start of vertical blanking. The frame in progress keeps the configuration it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register word index (0 base, 1 control) |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for `reg_addr` |
| mem_req | output | 1 | Word read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rdata | input | 32 | Returned pixel word |
| mem_valid | input | 1 | Returned word valid, one cycle after the request |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Visible-pixel data enable |
| red | output | 8 | Red level |
| green | output | 8 | Green level |
| blue | output | 8 | Blue level |

## Verification
The hardest case to reach from the ports is a register write that arrives while a frame is being drawn. It must leave the rest of that frame untouched and change only the next one. The stimulus therefore always writes both registers just after the first pixel of the second visible line. It then checks every remaining pixel of that frame against the old configuration, and every pixel of the following frame against the new one. Directed frames cover rotation with a base whose low bits are set, a base at the top of the address space, and a write that sets only the rotate bit. Random frames follow, with the base and control values drawn from `$urandom`.

// File: rtl/scanout_pkg.sv
package scanout_pkg;

  // Control register layout: bit 0 enable, bit 1 rotate.
  typedef struct packed {
    logic rot;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // Split a stored pixel word into its colour channels; the top byte is unused.
  function automatic rgb_t unpack_pixel(logic [31:0] w);
    rgb_t p;
    p.r = w[23:16];
    p.g = w[15:8];
    p.b = w[7:0];
    return p;
  endfunction

  // Source position along one axis, mirrored when rotation is on.
  function automatic int unsigned src_pos(int unsigned pos, int unsigned last, logic rot);
    return rot ? (last - pos) : pos;
  endfunction

  // Word offset of a pixel inside the frame.
  function automatic int unsigned word_offset(int unsigned row, int unsigned col,
                                              int unsigned stride);
    return row * stride + col;
  endfunction

endpackage

// File: rtl/scan_timing.sv
module scan_timing #(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int HC_W    = $clog2(H_TOTAL),
  localparam int VC_W    = $clog2(V_TOTAL)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [HC_W-1:0] hc,
  output logic [VC_W-1:0] vc,
  output logic            active,
  output logic            hsync_raw_n,
  output logic            vsync_raw_n,
  output logic            vblank_start
);

  localparam int HS_BEG = H_ACTIVE + H_FRONT;
  localparam int HS_END = HS_BEG + H_SYNC;
  localparam int VS_BEG = V_ACTIVE + V_FRONT;
  localparam int VS_END = VS_BEG + V_SYNC;

  logic line_last;
  assign line_last = (hc == HC_W'(H_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc <= '0;
      vc <= '0;
    end else if (line_last) begin
      hc <= '0;
      vc <= (vc == VC_W'(V_TOTAL - 1)) ? '0 : vc + 1'b1;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  always_comb begin
    active       = (hc < HC_W'(H_ACTIVE)) && (vc < VC_W'(V_ACTIVE));
    hsync_raw_n  = !((hc >= HC_W'(HS_BEG)) && (hc < HC_W'(HS_END)));
    vsync_raw_n  = !((vc >= VC_W'(VS_BEG)) && (vc < VC_W'(VS_END)));
    vblank_start = (hc == '0) && (vc == VC_W'(V_ACTIVE));
  end

  // R2: the column counter wraps to zero after the last clock of a line
  p_hwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_last |=> (hc == '0));

  // R3: the line counter only moves at the end of a line
  p_vhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !line_last |=> $stable(vc));

endmodule

// File: rtl/scan_regs.sv
module scan_regs
  import scanout_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BASE_KEEP = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              frame_latch,
  output logic [ADDR_W-1:0] cur_base,
  output ctrl_t             cur_ctrl
);

  localparam logic [ADDR_W-1:0] BASE_MASK =
    {{BASE_KEEP{1'b1}}, {(ADDR_W - BASE_KEEP){1'b0}}};

  logic [ADDR_W-1:0] base_q;
  ctrl_t             ctrl_q;

  // Software-visible copies: written at once, read back unchanged.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ctrl_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr) ctrl_q <= ctrl_t'(reg_wdata[1:0]);
      else          base_q <= reg_wdata;
    end
  end

  // Copies in use by the scan: refreshed only when vertical blanking begins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_base <= '0;
      cur_ctrl <= '0;
    end else if (frame_latch) begin
      cur_base <= base_q & BASE_MASK;
      cur_ctrl <= ctrl_q;
    end
  end

  assign reg_rdata = reg_addr ? {{(ADDR_W - 2){1'b0}}, ctrl_q} : base_q;

  // R4: a base write is held exactly as written
  p_base_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr) |=> (base_q == $past(reg_wdata)));

  // R10: the configuration in use changes only right after the blanking latch point
  p_latch_vblank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cur_base, cur_ctrl}) |-> $past(frame_latch));

endmodule

// File: rtl/scan_fetch.sv
module scan_fetch
  import scanout_pkg::*;
#(
  parameter int H_ACTIVE   = 640,
  parameter int V_ACTIVE   = 480,
  parameter int ROW_STRIDE = 1024,
  parameter int ADDR_W     = 32,
  parameter int HC_W       = 10,
  parameter int VC_W       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HC_W-1:0]   hc,
  input  logic [VC_W-1:0]   vc,
  input  logic              active,
  input  logic              hsync_raw_n,
  input  logic              vsync_raw_n,
  input  logic [ADDR_W-1:0] cur_base,
  input  ctrl_t             cur_ctrl,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_valid,
  output logic              de_o,
  output logic              hsync_o_n,
  output logic              vsync_o_n,
  output rgb_t              pix_o
);

  int unsigned row_src, col_src;
  logic [ADDR_W-1:0] word_off;

  always_comb begin
    row_src  = src_pos(int'(vc), V_ACTIVE - 1, cur_ctrl.rot);
    col_src  = src_pos(int'(hc), H_ACTIVE - 1, cur_ctrl.rot);
    word_off = ADDR_W'(word_offset(row_src, col_src, ROW_STRIDE));
    mem_addr = cur_base + (word_off << 2);
    mem_req  = active && cur_ctrl.en;
  end

  // Stage 1: timing aligned with the memory access in flight.
  logic s1_de, s1_hs_n, s1_vs_n, s1_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_de   <= 1'b0;
      s1_hs_n <= 1'b1;
      s1_vs_n <= 1'b1;
      s1_en   <= 1'b0;
    end else begin
      s1_de   <= active;
      s1_hs_n <= hsync_raw_n;
      s1_vs_n <= vsync_raw_n;
      s1_en   <= mem_req;
    end
  end

  // Stage 2: registered outputs with the returned word unpacked.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_o      <= 1'b0;
      hsync_o_n <= 1'b1;
      vsync_o_n <= 1'b1;
      pix_o     <= '0;
    end else begin
      de_o      <= s1_de;
      hsync_o_n <= s1_hs_n;
      vsync_o_n <= s1_vs_n;
      pix_o     <= (s1_de && s1_en && mem_valid) ? unpack_pixel(mem_rdata) : '0;
    end
  end

  // R6: consecutive requests along an unrotated line step forward one word
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req) && !cur_ctrl.rot) |-> (mem_addr == $past(mem_addr) + ADDR_W'(4)));

  // R7: consecutive requests along a rotated line step back one word
  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req) && cur_ctrl.rot) |-> (mem_addr == $past(mem_addr) - ADDR_W'(4)));

endmodule

// File: rtl/scanout_ctrl.sv
module scanout_ctrl
  import scanout_pkg::*;
#(
  parameter int H_ACTIVE   = 640,
  parameter int H_FRONT    = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BACK     = 48,
  parameter int V_ACTIVE   = 480,
  parameter int V_FRONT    = 10,
  parameter int V_SYNC     = 2,
  parameter int V_BACK     = 33,
  parameter int ROW_STRIDE = 1024,
  parameter int ADDR_W     = 32,
  parameter int BASE_KEEP  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_valid,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              de,
  output logic [7:0]        red,
  output logic [7:0]        green,
  output logic [7:0]        blue
);

  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HC_W    = $clog2(H_TOTAL);
  localparam int VC_W    = $clog2(V_TOTAL);

  logic [HC_W-1:0]   hc;
  logic [VC_W-1:0]   vc;
  logic              active, hs_raw_n, vs_raw_n, vblank_start;
  logic [ADDR_W-1:0] cur_base;
  ctrl_t             cur_ctrl;
  rgb_t              pix;

  scan_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .hc(hc), .vc(vc), .active(active),
    .hsync_raw_n(hs_raw_n), .vsync_raw_n(vs_raw_n), .vblank_start(vblank_start)
  );

  scan_regs #(.ADDR_W(ADDR_W), .BASE_KEEP(BASE_KEEP)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_latch(vblank_start),
    .cur_base(cur_base), .cur_ctrl(cur_ctrl)
  );

  scan_fetch #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .ROW_STRIDE(ROW_STRIDE),
    .ADDR_W(ADDR_W), .HC_W(HC_W), .VC_W(VC_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .hc(hc), .vc(vc), .active(active),
    .hsync_raw_n(hs_raw_n), .vsync_raw_n(vs_raw_n),
    .cur_base(cur_base), .cur_ctrl(cur_ctrl),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_valid(mem_valid),
    .de_o(de), .hsync_o_n(hsync_n), .vsync_o_n(vsync_n), .pix_o(pix)
  );

  assign red   = pix.r;
  assign green = pix.g;
  assign blue  = pix.b;

endmodule

// File: tb/tb_scanout_ctrl.sv
module tb_scanout_ctrl;

  localparam int HA = 8, HF = 2, HS = 3, HB = 3;
  localparam int VA = 6, VF = 2, VS = 2, VB = 3;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int STRIDE = 16;
  localparam int KEEP = 11;
  localparam logic [31:0] MASK = {{KEEP{1'b1}}, {(32 - KEEP){1'b0}}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata;
  logic mem_valid;
  logic hsync_n, vsync_n, de;
  logic [7:0] red, green, blue;

  always #2.5 clk = ~clk;

  scanout_ctrl #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .ROW_STRIDE(STRIDE), .ADDR_W(32), .BASE_KEEP(KEEP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_valid(mem_valid),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
    .red(red), .green(green), .blue(blue)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory contents: a hash of the address, with junk in the top byte.
  function automatic logic [31:0] pattern(logic [31:0] a);
    logic [31:0] h;
    h = (a >> 2) * 32'h9E3779B1;
    return {~a[9:2], h[23:0] ^ a[31:8]};
  endfunction

  // One-cycle memory model.
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_valid <= mem_req;
      mem_rdata <= pattern(mem_addr);
    end
  end

  // Register shadows and the configuration expected for the frame on screen.
  logic [31:0] sh_base = '0;
  logic [1:0]  sh_ctrl = '0;
  logic [31:0] ex_base = '0;
  logic [1:0]  ex_ctrl = '0;

  function automatic logic [23:0] exp_pixel(int x, int y);
    int row, col;
    logic [31:0] a;
    if (!ex_ctrl[0]) return 24'h0;
    row = ex_ctrl[1] ? (VA - 1 - y) : y;
    col = ex_ctrl[1] ? (HA - 1 - x) : x;
    a = (ex_base & MASK) + 32'((row * STRIDE + col) * 4);
    return pattern(a)[23:0];
  endfunction

  // Output monitor.
  int x, y, hcyc, fcyc, hlow, vlow, gap_h, gap_v, reqs, vs_falls;
  bit prev_de, prev_hs, prev_vs, seen_hs, seen_vs, armed_h;

  always @(negedge clk) begin
    if (!rst_n) begin
      x = 0; y = 0; hcyc = 0; fcyc = 0; hlow = 0; vlow = 0;
      gap_h = 0; gap_v = 0; reqs = 0; vs_falls = 0;
      prev_de = 0; prev_hs = 1; prev_vs = 1;
      seen_hs = 0; seen_vs = 0; armed_h = 0;
    end else begin
      if (mem_req) reqs++;
      hcyc++; fcyc++; gap_h++; gap_v++;
      if (de) begin
        // R5 R6 R7 R8 R9, and R10: pixels follow the frame's own configuration
        check({red, green, blue} == exp_pixel(x, y),
              ex_ctrl[0] ? (ex_ctrl[1] ? "R5 R7 R8 R10" : "R5 R6 R8 R10") : "R9 R10",
              {red, green, blue}, exp_pixel(x, y));
        x++;
      end else begin
        check({red, green, blue} == 24'h0, "R9 blank colour", {red, green, blue}, 0);
      end
      if (prev_de && !de) begin
        check(x == HA, "R2 de width", x, HA);
        x = 0; y++; gap_h = 0; gap_v = 0; armed_h = 1;
      end
      if (prev_hs && !hsync_n) begin
        if (seen_hs) check(hcyc == HT, "R2 line period", hcyc, HT);
        if (armed_h) check(gap_h == HF, "R2 front porch", gap_h, HF);
        hcyc = 0; seen_hs = 1; armed_h = 0; hlow = 0;
      end
      if (!hsync_n) hlow++;
      if (!prev_hs && hsync_n) check(hlow == HS, "R2 hsync width", hlow, HS);
      if (prev_vs && !vsync_n) begin
        check(y == VA, "R3 visible lines", y, VA);
        check(reqs == (ex_ctrl[0] ? HA * VA : 0), ex_ctrl[0] ? "R6 request count" : "R9 no requests",
              reqs, ex_ctrl[0] ? HA * VA : 0);
        check(gap_v == (HT - HA) + VF * HT, "R3 vsync position", gap_v, (HT - HA) + VF * HT);
        if (seen_vs) check(fcyc == HT * VT, "R3 frame period", fcyc, HT * VT);
        y = 0; reqs = 0; fcyc = 0; vlow = 0; seen_vs = 1;
        ex_base = sh_base; ex_ctrl = sh_ctrl;
        vs_falls++;
      end
      if (!vsync_n) vlow++;
      if (!prev_vs && vsync_n) check(vlow == VS * HT, "R3 vsync width", vlow, VS * HT);
      prev_de = de; prev_hs = hsync_n; prev_vs = vsync_n;
    end
  end

  task automatic wr_reg(bit a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0;
    if (a) sh_ctrl = d[1:0]; else sh_base = d;
    #1;
    // R4: readback straight after the write
    check(reg_rdata == (a ? {30'h0, d[1:0]} : d), "R4 readback", reg_rdata,
          a ? {30'h0, d[1:0]} : d);
  endtask

  task automatic wait_vs_fall();
    int n;
    n = vs_falls;
    while (vs_falls == n) @(negedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    // R1: state under reset
    check(de == 1'b0 && {red, green, blue} == 24'h0, "R1 de/colour", {de, red, green, blue}, 0);
    check(hsync_n && vsync_n, "R1 syncs idle high", {hsync_n, vsync_n}, 2'b11);
    check(mem_req == 1'b0, "R1 no request", mem_req, 0);
    reg_addr = 1'b0; #1;
    check(reg_rdata == 32'h0, "R1 base reads 0", reg_rdata, 0);
    reg_addr = 1'b1; #1;
    check(reg_rdata == 32'h0, "R1 control reads 0", reg_rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check(de == 1'b0 && mem_req == 1'b0, "R1 after reset", {de, mem_req}, 0);

    for (int i = 0; i < 24; i++) begin
      logic [31:0] b, c;
      // Write mid-frame: just after the first pixel of the second line (R10)
      do begin @(negedge clk); #1; end while (!(y == 1 && de));
      case (i)
        0: begin b = 32'h0020_0000; c = 32'h1; end
        1: begin b = 32'h0041_ABCD; c = 32'h3; end
        2: begin b = 32'h0060_0000; c = 32'h0; end
        3: begin b = 32'hFFE0_0000; c = 32'h3; end
        4: begin b = 32'h1234_5678; c = 32'hFFFF_FFFE; end
        default: begin
          b = $urandom;
          c = $urandom;
          if (i % 4 != 0) c[0] = 1'b1;
        end
      endcase
      wr_reg(1'b0, b);
      wr_reg(1'b1, c);
      wait_vs_fall();
    end
    wait_vs_fall();
    wait_vs_fall();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule